// File: doc/BRIEF.md
# Segment Access Protection Checker

This block checks one memory access against the cached descriptor of the segment it goes through. It also forms the linear address of the access. A request carries the following:

- The descriptor fields: base, limit, present, descriptor privilege, selector requested privilege, executable and read/write.
- The offset and byte size of the access.
- The kind of access: data read, instruction fetch or write.
- The current privilege level.
- The protection-enable bit.

One cycle after a request, the block reports a verdict. The verdict is one of three results: the access is allowed, it takes a general-protection fault, or it takes a segment-not-present fault.

Faults are resolved in a fixed priority. The limit check comes first and applies in every mode. The presence check comes next, then privilege, then type. The presence, privilege and type checks apply only while protection is enabled. An address-generation stage uses the result to decide between issuing the linear address and raising an exception.

Top module: `seg_access_guard`

## Requirements
- R1: An access whose end offset (offset + size - 1, computed at 33 bits so that a carry past 2^32 counts) is greater than the limit returns fault code 2'b01 (general protection). This holds with protection on or off, and it takes priority over every other check.
- R2: With `prot_en` low, only the limit check applies. Presence, privilege and type never cause a fault in that mode.
- R3: With `prot_en` high and `seg_present` low, an access within the limit returns fault code 2'b10 (segment not present). This happens even when privilege or type would also fail.
- R4: For data reads (kind 2'b00 or 2'b11) and writes (kind 2'b10), the access faults with code 2'b01 when the selector privilege is greater than the descriptor privilege. It also faults with code 2'b01 when the current privilege is greater than the descriptor privilege.
- R5: For instruction fetches (kind 2'b01), only the current privilege is compared against the descriptor privilege. The selector privilege has no effect.
- R6: A fetch from a segment with `seg_exec` low faults with code 2'b01. A read from a segment with `seg_exec` high and `seg_rw` low faults with code 2'b01. A read from a data segment is allowed whatever the value of `seg_rw`.
- R7: A write to a segment with `seg_exec` high always faults with code 2'b01. A write to a data segment with `seg_rw` low also faults with code 2'b01.
- R8: For an allowed access, `rsp_lin_addr` equals `seg_base + acc_offset` modulo 2^32.
- R9: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. This holds for back-to-back requests. In cycles where `rsp_valid` is low, `rsp_ok` is low and `rsp_fault` is 2'b00.
- R10: After reset, `rsp_valid` and `rsp_ok` are low, `rsp_fault` is 2'b00 and `rsp_lin_addr` is zero.
- R11: While `rsp_valid` is high, `rsp_ok` is high exactly when `rsp_fault` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 32 | Highest valid offset in the segment |
| seg_present | input | 1 | Descriptor present bit |
| seg_dpl | input | 2 | Descriptor privilege level |
| sel_rpl | input | 2 | Requested privilege level of the selector |
| seg_exec | input | 1 | Segment is a code segment |
| seg_rw | input | 1 | Readable (code segment) or writable (data segment) |
| acc_offset | input | 32 | Offset of the access within the segment |
| acc_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| acc_kind | input | 2 | 00 read, 01 fetch, 10 write, 11 read |
| cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protection-enable bit |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 2 | 00 none, 01 general protection, 10 not present |
| rsp_lin_addr | output | 32 | Linear address; meaningful only when rsp_ok is high |

## Verification
The only state is a single output register stage, so any fault in it appears at the ports in the very cycle after the request.

- A wrong priority in the fault chain shows up as the wrong fault code. Examples are a not-present descriptor that reports general protection, or a limit overrun that reports not present.
- A lost carry in the end-offset sum lets an access that wraps past 2^32 report as allowed.

The vectors combine several failing conditions in one access so that the priority order is visible. They also place the end offset exactly on the limit and one byte past it.

// File: rtl/seg_access_guard.sv
module seg_access_guard #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              seg_present,
  input  logic [1:0]        seg_dpl,
  input  logic [1:0]        sel_rpl,
  input  logic              seg_exec,
  input  logic              seg_rw,
  input  logic [ADDR_W-1:0] acc_offset,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        cpl,
  input  logic              prot_en,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [1:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_lin_addr
);
  localparam int END_W = ADDR_W + 1;
  localparam logic [1:0] K_FETCH = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;
  localparam logic [1:0] F_NONE  = 2'b00;
  localparam logic [1:0] F_GP    = 2'b01;
  localparam logic [1:0] F_NP    = 2'b10;

  logic [END_W-1:0] end_ofs;
  logic             over_limit, priv_bad;
  logic             type_bad;
  logic [1:0]       fault_d;

  assign end_ofs    = {1'b0, acc_offset} + END_W'(acc_size) - END_W'(1);
  assign over_limit = end_ofs > {1'b0, seg_limit};
  assign priv_bad   = (cpl > seg_dpl) || ((acc_kind != K_FETCH) && (sel_rpl > seg_dpl));

  always_comb begin
    case (acc_kind)
      K_FETCH: type_bad = !seg_exec;
      K_WRITE: type_bad = seg_exec || !seg_rw;
      default: type_bad = seg_exec && !seg_rw;
    endcase
  end

  always_comb begin
    if (over_limit)                fault_d = F_GP;
    else if (!prot_en)             fault_d = F_NONE;
    else if (!seg_present)         fault_d = F_NP;
    else if (priv_bad || type_bad) fault_d = F_GP;
    else                           fault_d = F_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_ok       <= 1'b0;
      rsp_fault    <= F_NONE;
      rsp_lin_addr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= req_valid && (fault_d == F_NONE);
      rsp_fault <= req_valid ? fault_d : F_NONE;
      if (req_valid) rsp_lin_addr <= seg_base + acc_offset;
    end
  end
endmodule

// File: rtl/seg_access_guard_chk.sv
module seg_access_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] seg_base,
  input logic [ADDR_W-1:0] seg_limit,
  input logic              seg_present,
  input logic              seg_exec,
  input logic [ADDR_W-1:0] acc_offset,
  input logic [SIZE_W-1:0] acc_size,
  input logic [1:0]        acc_kind,
  input logic              prot_en,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic [1:0]        rsp_fault,
  input logic [ADDR_W-1:0] rsp_lin_addr
);
  logic [ADDR_W:0] chk_end;
  logic            chk_over;
  assign chk_end  = {1'b0, acc_offset} + (ADDR_W+1)'(acc_size) - (ADDR_W+1)'(1);
  assign chk_over = chk_end > {1'b0, seg_limit};

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_ok && rsp_fault == 2'b00)); // R9
  AST_OK_MATCHES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok == (rsp_fault == 2'b00))); // R11
  AST_LIMIT_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && chk_over) |=> (rsp_fault == 2'b01)); // R1
  AST_REAL_MODE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en && !chk_over) |=> rsp_ok); // R2
  AST_NP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b10) |-> ($past(prot_en) && !$past(seg_present))); // R3
  AST_WRITE_CODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_en && acc_kind == 2'b10 && seg_exec) |=> !rsp_ok); // R7
  AST_LIN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |-> (rsp_lin_addr == ADDR_W'($past(seg_base) + $past(acc_offset)))); // R8
endmodule

bind seg_access_guard seg_access_guard_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_base(seg_base),
  .seg_limit(seg_limit), .seg_present(seg_present), .seg_exec(seg_exec),
  .acc_offset(acc_offset), .acc_size(acc_size), .acc_kind(acc_kind),
  .prot_en(prot_en), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
  .rsp_fault(rsp_fault), .rsp_lin_addr(rsp_lin_addr)
);

// File: tb/sim_seg_access_guard.sv
`timescale 1ns/1ps
module sim_seg_access_guard;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [31:0] seg_base = '0, seg_limit = '0, acc_offset = '0;
  logic seg_present = 1'b0, seg_exec = 1'b0, seg_rw = 1'b0, prot_en = 1'b0;
  logic [1:0] seg_dpl = '0, sel_rpl = '0, acc_kind = '0, cpl = '0;
  logic [2:0] acc_size = 3'd1;
  logic rsp_valid, rsp_ok;
  logic [1:0] rsp_fault;
  logic [31:0] rsp_lin_addr;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0, armed = 0;
  logic [1:0]  q_fault[$];
  logic [31:0] q_addr[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  seg_access_guard u0 (.*);

  task automatic check(string tag, bit good, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic [31:0] b, logic [31:0] lim, logic p,
                      logic [1:0] dpl, logic [1:0] rpl, logic x, logic rw,
                      logic [31:0] off, logic [2:0] sz, logic [1:0] kind,
                      logic [1:0] c, logic pe, logic [1:0] exp_fault);
    @(negedge clk);
    seg_base = b; seg_limit = lim; seg_present = p; seg_dpl = dpl; sel_rpl = rpl;
    seg_exec = x; seg_rw = rw; acc_offset = off; acc_size = sz; acc_kind = kind;
    cpl = c; prot_en = pe; req_valid = 1'b1;
    q_fault.push_back(exp_fault);
    q_addr.push_back(b + off);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      if (rsp_valid) begin
        if (q_fault.size() == 0) begin
          check("R9 unexpected response", 1'b0, 64'(rsp_valid), 64'(0));
        end else begin
          logic [1:0] ef;
          logic [31:0] ea;
          string t;
          ef = q_fault.pop_front(); ea = q_addr.pop_front(); t = q_tag.pop_front();
          check({t, " fault"}, rsp_fault == ef, 64'(rsp_fault), 64'(ef));
          check({t, " R11 ok"}, rsp_ok == (ef == 2'b00), 64'(rsp_ok), 64'(ef == 2'b00));
          if (ef == 2'b00) check({t, " R8 addr"}, rsp_lin_addr == ea, 64'(rsp_lin_addr), 64'(ea));
        end
      end else begin
        check("R9 idle outputs", !rsp_ok && rsp_fault == 2'b00, 64'({rsp_ok, rsp_fault}), 64'(0));
        check("R9 missing response", q_fault.size() == 0 || req_valid, 64'(q_fault.size()), 64'(0));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      check("watchdog", 1'b0, 64'(cycles), 64'(0));
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", !rsp_valid && !rsp_ok && rsp_fault == 2'b00 && rsp_lin_addr == 0,
          64'({rsp_valid, rsp_ok, rsp_fault}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    armed = 1;
    // R1 limit: exact end, one past, real mode, 33-bit wrap
    send("R1 end on limit", 32'h1000, 32'hFF, 1, 0, 0, 0, 1, 32'hFE, 2, 2'b00, 0, 1, 2'b00);
    send("R1 past limit",   32'h1000, 32'hFF, 1, 0, 0, 0, 1, 32'hFE, 4, 2'b00, 0, 1, 2'b01);
    send("R1 real mode",    32'h1000, 32'hFF, 0, 3, 3, 1, 0, 32'hFF, 2, 2'b10, 3, 0, 2'b01);
    send("R1 wrap",         32'h0, 32'hFFFFFFFF, 1, 0, 0, 0, 1, 32'hFFFFFFFE, 4, 2'b00, 0, 1, 2'b01);
    send("R1 top word ok",  32'h0, 32'hFFFFFFFF, 1, 0, 0, 0, 1, 32'hFFFFFFFC, 4, 2'b00, 0, 1, 2'b00);
    send("R1 over NP",      32'h0, 32'h10, 0, 0, 0, 0, 1, 32'h10, 2, 2'b00, 0, 1, 2'b01);
    // R2 real mode ignores presence, privilege, type
    send("R2 real mode",    32'h2000, 32'hFFFF, 0, 0, 3, 1, 0, 32'h40, 4, 2'b10, 3, 0, 2'b00);
    idle(2);
    // R3 not present wins over privilege and type
    send("R3 NP",           32'h0, 32'hFFFF, 0, 0, 3, 1, 0, 32'h4, 1, 2'b10, 3, 1, 2'b10);
    send("R3 NP fetch",     32'h0, 32'hFFFF, 0, 0, 0, 0, 0, 32'h4, 1, 2'b01, 0, 1, 2'b10);
    // R4 data privilege
    send("R4 rpl>dpl read", 32'h0, 32'hFFFF, 1, 2, 3, 0, 1, 32'h8, 4, 2'b00, 0, 1, 2'b01);
    send("R4 cpl>dpl read", 32'h0, 32'hFFFF, 1, 2, 0, 0, 1, 32'h8, 4, 2'b11, 3, 1, 2'b01);
    send("R4 equal ok",     32'h0, 32'hFFFF, 1, 2, 2, 0, 1, 32'h8, 4, 2'b00, 2, 1, 2'b00);
    send("R4 rpl>dpl write",32'h0, 32'hFFFF, 1, 1, 2, 0, 1, 32'h8, 2, 2'b10, 0, 1, 2'b01);
    // R5 fetch ignores RPL
    send("R5 fetch rpl",    32'h500, 32'hFFFF, 1, 0, 3, 1, 0, 32'h10, 1, 2'b01, 0, 1, 2'b00);
    send("R5 fetch cpl",    32'h500, 32'hFFFF, 1, 0, 0, 1, 0, 32'h10, 1, 2'b01, 1, 1, 2'b01);
    // R6 fetch and read types
    send("R6 fetch data",   32'h0, 32'hFFFF, 1, 3, 0, 0, 1, 32'h10, 1, 2'b01, 0, 1, 2'b01);
    send("R6 read code xr", 32'h0, 32'hFFFF, 1, 3, 0, 1, 0, 32'h10, 2, 2'b00, 0, 1, 2'b01);
    send("R6 read code r",  32'h0, 32'hFFFF, 1, 3, 0, 1, 1, 32'h10, 2, 2'b00, 0, 1, 2'b00);
    send("R6 read data ro", 32'h0, 32'hFFFF, 1, 3, 0, 0, 0, 32'h10, 2, 2'b11, 0, 1, 2'b00);
    idle(1);
    // R7 write types
    send("R7 write code",   32'h0, 32'hFFFF, 1, 3, 0, 1, 1, 32'h20, 4, 2'b10, 0, 1, 2'b01);
    send("R7 write ro",     32'h0, 32'hFFFF, 1, 3, 0, 0, 0, 32'h20, 4, 2'b10, 0, 1, 2'b01);
    send("R7 write rw",     32'h0, 32'hFFFF, 1, 3, 0, 0, 1, 32'h20, 4, 2'b10, 0, 1, 2'b00);
    // R8 address wraps modulo 2^32
    send("R8 wrap addr",    32'hFFFFF000, 32'hFFFFFFFF, 1, 0, 0, 0, 1, 32'h2000, 4, 2'b00, 0, 1, 2'b00);
    idle(3);
    check("R9 queue drained", q_fault.size() == 0, 64'(q_fault.size()), 64'(0));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule